// File: doc/BRIEF.md
# HDLC Frame Address Filter

This block sits behind the byte assembler of an HDLC receiver and decides, for every received frame, whether the frame is addressed to this station. It watches the byte stream and notes the first byte of each frame. Bit 0 of that byte is the address extension bit. If the bit is 1, the address is one byte long. If the bit is 0, the address is two bytes long, and the next byte of the frame is the second address byte.

Each of the two programmed reference bytes has its own compare enable, so either byte, both or neither takes part in the comparison. An all-ones address is always accepted. When the second byte of a two-byte address is all ones, the first byte is not compared at all. Single-byte addresses are normally compared on bits 7:2. An optional seven-bit mode widens that compare to bits 7:1. When filtering is switched off, every frame is accepted.

The verdict is a one-cycle pulse, issued once per frame as soon as the last address byte has been taken in. The downstream writer uses it to keep or drop the frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: While reset is asserted, and for the cycles before the first byte arrives, `verdict_valid` and `verdict_accept` are 0.
- R2: A byte with `rx_valid`=1 and `rx_first`=1 whose bit 0 is 1 is a single-byte address. The cycle after it, `verdict_valid` is 1 for exactly one cycle.
- R3: A first byte whose bit 0 is 0 gives no verdict in the next cycle. The next byte with `rx_valid`=1 and `rx_first`=0 is the second address byte, and the verdict follows one cycle after it.
- R4: With `filt_on`=0, every verdict has `verdict_accept`=1.
- R5: With `filt_on`=1 and both `ref1_on` and `ref2_on` at 0, every verdict has `verdict_accept`=1.
- R6: Two-byte address. When `ref1_on`=1, bits 7:2 of the first byte must equal bits 7:2 of `ref1_byte`. When `ref2_on`=1, the whole second byte must equal `ref2_byte` or be 8'hFF.
- R7: Two-byte address. If the second byte is 8'hFF, the first byte is not compared, and the frame is accepted whenever the second byte passes.
- R8: Single-byte address with `seven_mode`=0 and `ref1_on`=1. The frame is accepted when bits 7:2 equal those of `ref1_byte`, or when bits 7:2 are all ones. `ref2_on` and `ref2_byte` have no effect on the result.
- R9: With `seven_mode`=1, a single-byte address is compared, and checked for all ones, on bits 7:1. Two-byte addresses still use bits 7:2.
- R10: No other byte produces a verdict: payload bytes, and bytes arriving outside a frame, give `verdict_valid`=0. A new `rx_first` byte that arrives while a second address byte is awaited restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_first | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Received byte; bit 0 of a first byte is the extension bit |
| ref1_byte | input | 8 | Reference value for the first address byte |
| ref1_on | input | 1 | Enables the compare of the first address byte |
| ref2_byte | input | 8 | Reference value for the second address byte |
| ref2_on | input | 1 | Enables the compare of the second address byte |
| filt_on | input | 1 | 0 accepts every frame |
| seven_mode | input | 1 | Widens the single-byte compare to bits 7:1 |
| verdict_valid | output | 1 | One-cycle pulse carrying the verdict for the current frame |
| verdict_accept | output | 1 | 1 means keep the frame; valid only while `verdict_valid` is 1 |

## Verification
The assertions assume that the reference bytes, enables and mode inputs do not change from the first byte of a frame until its verdict. They also assume that no byte arrives in the first cycles after reset is released, while the internal reset is still held. The bench draws a fresh configuration only between frames, holds it for the whole frame, and waits several cycles after reset before sending the first byte. Random address bytes are skewed toward exact matches, all-ones values and single-bit differences, so that every compare path is hit. Directed frames cover address restarts and stray bytes.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef logic [BYTE_W-1:0] addr_byte_t;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_WAIT_B2 = 2'd1,
    SEQ_PAYLOAD = 2'd2
  } seq_state_e;

  typedef struct packed {
    addr_byte_t b1;
    addr_byte_t b2;
    logic       single;
  } addr_pair_t;
endpackage

// File: rtl/afilt_seq.sv
module afilt_seq
  import afilt_pkg::*;
#(
  parameter int unsigned EXT_BIT = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_first,
  input  addr_byte_t in_byte,
  output addr_pair_t pair,
  output logic       pair_ready
);
  seq_state_e state_q, state_d;
  addr_byte_t b1_q;
  logic       b1_load;

  always_comb begin
    state_d     = state_q;
    b1_load     = 1'b0;
    pair_ready  = 1'b0;
    pair.b1     = in_byte;
    pair.b2     = '0;
    pair.single = in_byte[EXT_BIT];
    if (in_valid && in_first) begin
      b1_load = 1'b1;
      if (in_byte[EXT_BIT]) begin
        pair_ready = 1'b1;
        state_d    = SEQ_PAYLOAD;
      end else begin
        state_d    = SEQ_WAIT_B2;
      end
    end else if (in_valid && (state_q == SEQ_WAIT_B2)) begin
      pair_ready  = 1'b1;
      pair.b1     = b1_q;
      pair.b2     = in_byte;
      pair.single = 1'b0;
      state_d     = SEQ_PAYLOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b1_q <= '0;
    end else if (b1_load) begin
      b1_q <= in_byte;
    end
  end
endmodule

// File: rtl/afilt_field_cmp.sv
module afilt_field_cmp
  import afilt_pkg::*;
(
  input  addr_byte_t value,
  input  addr_byte_t ref_value,
  input  addr_byte_t mask,
  output logic       equal,
  output logic       all_ones
);
  always_comb begin
    equal    = (((value ^ ref_value) & mask) == '0);
    all_ones = ((value & mask) == mask);
  end
endmodule

// File: rtl/afilt_match.sv
module afilt_match
  import afilt_pkg::*;
#(
  parameter int unsigned SHORT_LSB = 2,
  parameter int unsigned LONG_LSB  = 1
) (
  input  addr_pair_t pair,
  input  addr_byte_t ref1,
  input  logic       ref1_en,
  input  addr_byte_t ref2,
  input  logic       ref2_en,
  input  logic       filter_en,
  input  logic       seven,
  output logic       accept
);
  localparam addr_byte_t FULL_MASK  = {BYTE_W{1'b1}};
  localparam addr_byte_t SHORT_MASK = FULL_MASK << SHORT_LSB;
  localparam addr_byte_t LONG_MASK  = FULL_MASK << LONG_LSB;
  localparam int unsigned SLOTS     = 2;

  addr_byte_t slot_val  [SLOTS];
  addr_byte_t slot_ref  [SLOTS];
  addr_byte_t slot_mask [SLOTS];
  logic [SLOTS-1:0] slot_eq;
  logic [SLOTS-1:0] slot_ones;
  logic pass1, pass2;

  always_comb begin
    slot_val[0]  = pair.b1;
    slot_ref[0]  = ref1;
    slot_mask[0] = (pair.single && seven) ? LONG_MASK : SHORT_MASK;
    slot_val[1]  = pair.b2;
    slot_ref[1]  = ref2;
    slot_mask[1] = FULL_MASK;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    afilt_field_cmp u_cmp (
      .value     (slot_val[s]),
      .ref_value (slot_ref[s]),
      .mask      (slot_mask[s]),
      .equal     (slot_eq[s]),
      .all_ones  (slot_ones[s])
    );
  end

  always_comb begin
    pass1 = !ref1_en || slot_eq[0] || (pair.single && slot_ones[0]);
    pass2 = !ref2_en || slot_eq[1] || slot_ones[1];
    if (!filter_en) begin
      accept = 1'b1;
    end else if (pair.single) begin
      accept = pass1;
    end else begin
      accept = pass2 && (pass1 || slot_ones[1]);
    end
  end
endmodule

// File: rtl/afilt_verdict.sv
module afilt_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic accept,
  output logic out_valid,
  output logic out_accept
);
  logic valid_d, accept_d;

  always_comb begin
    valid_d  = ready;
    accept_d = ready ? accept : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      out_accept <= accept_d;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import afilt_pkg::*;
#(
  parameter int unsigned EXT_BIT   = 0,
  parameter int unsigned SHORT_LSB = 2,
  parameter int unsigned LONG_LSB  = 1,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_first,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] ref1_byte,
  input  logic              ref1_on,
  input  logic [BYTE_W-1:0] ref2_byte,
  input  logic              ref2_on,
  input  logic              filt_on,
  input  logic              seven_mode,
  output logic              verdict_valid,
  output logic              verdict_accept
);
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_core_n;
  addr_pair_t          pair;
  logic                pair_ready;
  logic                accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[SYNC_LEN-1];

  afilt_seq #(.EXT_BIT(EXT_BIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid   (rx_valid),
    .in_first   (rx_first),
    .in_byte    (rx_byte),
    .pair       (pair),
    .pair_ready (pair_ready)
  );

  afilt_match #(.SHORT_LSB(SHORT_LSB), .LONG_LSB(LONG_LSB)) u_match (
    .pair      (pair),
    .ref1      (ref1_byte),
    .ref1_en   (ref1_on),
    .ref2      (ref2_byte),
    .ref2_en   (ref2_on),
    .filter_en (filt_on),
    .seven     (seven_mode),
    .accept    (accept)
  );

  afilt_verdict u_verdict (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ready      (pair_ready),
    .accept     (accept),
    .out_valid  (verdict_valid),
    .out_accept (verdict_accept)
  );
endmodule

// File: rtl/afilt_checker.sv
module afilt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic       rx_first,
  input logic [7:0] rx_byte,
  input logic       ref1_on,
  input logic       ref2_on,
  input logic       filt_on,
  input logic       verdict_valid,
  input logic       verdict_accept
);
  // R2: a single-byte first byte is followed by a verdict
  assert_single_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first && rx_byte[0]) |=> verdict_valid);

  // R3: a two-byte first byte never gives an immediate verdict
  assert_dual_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first && !rx_byte[0]) |=> !verdict_valid);

  // R4: filtering off accepts everything
  assert_bypass_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !filt_on) |=> (!verdict_valid || verdict_accept));

  // R5: both compares disabled accepts everything
  assert_no_compare_accepts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !ref1_on && !ref2_on) |=> (!verdict_valid || verdict_accept));

  // R10: no verdict without a byte
  assert_no_byte_no_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !verdict_valid);

  // R1: accept never stands without a verdict pulse
  assert_accept_qualified_R1: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_accept |-> verdict_valid);
endmodule

bind hdlc_addr_filter afilt_checker i_afilt_checker (
  .clk            (clk),
  .rst_n          (rst_core_n),
  .rx_valid       (rx_valid),
  .rx_first       (rx_first),
  .rx_byte        (rx_byte),
  .ref1_on        (ref1_on),
  .ref2_on        (ref2_on),
  .filt_on        (filt_on),
  .verdict_valid  (verdict_valid),
  .verdict_accept (verdict_accept)
);

// File: tb/test_hdlc_addr_filter.sv
module test_hdlc_addr_filter;
  logic       clk;
  logic       rst_n;
  logic       rx_valid, rx_first;
  logic [7:0] rx_byte, ref1_byte, ref2_byte;
  logic       ref1_on, ref2_on, filt_on, seven_mode;
  logic       verdict_valid, verdict_accept;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hdlc_addr_filter i_hdlc_addr_filter (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_byte(rx_byte), .ref1_byte(ref1_byte), .ref1_on(ref1_on),
    .ref2_byte(ref2_byte), .ref2_on(ref2_on), .filt_on(filt_on),
    .seven_mode(seven_mode), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference decision, written from the requirements
  function automatic bit expect_accept(input logic [7:0] a1, input logic [7:0] a2);
    bit single, p1, p2, b2_ff;
    logic [7:0] m;
    if (!filt_on) return 1'b1;
    single = a1[0];
    if (single) begin
      m = seven_mode ? 8'b1111_1110 : 8'b1111_1100;
      p1 = !ref1_on || ((a1 & m) == (ref1_byte & m)) || ((a1 & m) == m);
      return p1;
    end
    b2_ff = (a2 == 8'hFF);
    p1 = !ref1_on || (a1[7:2] == ref1_byte[7:2]);
    p2 = !ref2_on || (a2 == ref2_byte) || b2_ff;
    return p2 && (p1 || b2_ff);
  endfunction

  function automatic string tag_for(input logic [7:0] a1, input logic [7:0] a2);
    if (!filt_on) return "R4";
    if (!ref1_on && !ref2_on) return "R5";
    if (a1[0]) return seven_mode ? "R9" : "R8";
    if (a2 == 8'hFF) return "R7";
    return "R6";
  endfunction

  function automatic logic [7:0] pick_byte(input logic [7:0] refv);
    int r;
    r = $urandom_range(0, 99);
    if (r < 45) return refv ^ ({7'd0, 1'b1} << $urandom_range(0, 1));
    if (r < 60) return refv ^ (8'd1 << $urandom_range(0, 7));
    if (r < 75) return 8'hFF ^ {7'd0, r[0]};
    return 8'($urandom);
  endfunction

  task automatic send_frame(input logic [7:0] a1, input logic [7:0] a2, input int trail);
    bit exp;
    exp = expect_accept(a1, a2);
    rx_valid = 1'b1; rx_first = 1'b1; rx_byte = a1;
    @(negedge clk);
    if (a1[0]) begin
      check(verdict_valid === 1'b1, "R2 verdict after single byte", verdict_valid, 1);
      check(verdict_accept === exp, tag_for(a1, a2), verdict_accept, exp);
    end else begin
      check(verdict_valid === 1'b0, "R3 no early verdict", verdict_valid, 0);
      rx_first = 1'b0; rx_byte = a2;
      @(negedge clk);
      check(verdict_valid === 1'b1, "R3 verdict after second byte", verdict_valid, 1);
      check(verdict_accept === exp, tag_for(a1, a2), verdict_accept, exp);
    end
    for (int t = 0; t < trail; t++) begin
      rx_first = 1'b0; rx_byte = 8'($urandom);
      @(negedge clk);
      check(verdict_valid === 1'b0, "R10 payload gives no verdict", verdict_valid, 0);
    end
    rx_valid = 1'b0;
    @(negedge clk);
    check(verdict_valid === 1'b0, "R10 idle gives no verdict", verdict_valid, 0);
  endtask

  task automatic set_cfg(input logic [7:0] r1, input bit e1, input logic [7:0] r2,
                         input bit e2, input bit f, input bit s);
    ref1_byte = r1; ref1_on = e1; ref2_byte = r2; ref2_on = e2;
    filt_on = f; seven_mode = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rx_valid = 1'b0; rx_first = 1'b0; rx_byte = 8'h00;
    set_cfg(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(verdict_valid === 1'b0, "R1 reset valid", verdict_valid, 0);
    check(verdict_accept === 1'b0, "R1 reset accept", verdict_accept, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(verdict_valid === 1'b0, "R1 quiet after reset", verdict_valid, 0);

    // Directed corner cases
    set_cfg(8'hA5, 1, 8'h3C, 1, 1, 0);
    send_frame(8'h10, 8'hFF, 0);            // R7: bad first byte skipped by all-call
    send_frame(8'hA4, 8'h3C, 1);            // R6: 7:2 match, exact second byte
    send_frame(8'hA8, 8'h3C, 0);            // R6: first byte mismatch
    send_frame(8'hA5, 8'h12, 2);            // R8: single, second byte ignored
    send_frame(8'hFD, 8'h00, 0);            // R8: all ones on 7:2
    set_cfg(8'hA5, 1, 8'h3C, 1, 1, 1);
    send_frame(8'hA7, 8'h00, 0);            // R9: bit 1 differs, reject
    send_frame(8'hFD, 8'h00, 0);            // R9: 7:1 not all ones, reject
    send_frame(8'hFF, 8'h00, 0);            // R9: all-call
    send_frame(8'hA6, 8'h3C, 0);            // R9 does not affect two-byte compare
    set_cfg(8'hA5, 0, 8'h3C, 0, 1, 0);
    send_frame(8'h00, 8'h11, 0);            // R5
    set_cfg(8'hA5, 1, 8'h3C, 1, 0, 0);
    send_frame(8'h02, 8'h11, 0);            // R4

    // R10: stray byte outside a frame, and restart during the address phase
    set_cfg(8'h41, 1, 8'h3C, 1, 1, 0);
    rx_valid = 1'b1; rx_first = 1'b0; rx_byte = 8'h3C;
    @(negedge clk);
    check(verdict_valid === 1'b0, "R10 stray byte", verdict_valid, 0);
    rx_first = 1'b1; rx_byte = 8'h40;          // two-byte start
    @(negedge clk);
    check(verdict_valid === 1'b0, "R10 first of aborted address", verdict_valid, 0);
    rx_first = 1'b1; rx_byte = 8'h41;          // restart as single-byte
    @(negedge clk);
    check(verdict_valid === 1'b1, "R10 restart verdict", verdict_valid, 1);
    check(verdict_accept === 1'b1, "R10 restart accept", verdict_accept, 1);
    rx_valid = 1'b0;
    @(negedge clk);

    // Constrained random frames
    for (int n = 0; n < 400; n++) begin
      logic [7:0] r1, r2, a1, a2;
      r1 = 8'($urandom); r2 = 8'($urandom);
      set_cfg(r1, 1'($urandom_range(0, 3) != 0), r2, 1'($urandom_range(0, 3) != 0),
              1'($urandom_range(0, 7) != 0), 1'($urandom));
      a1 = pick_byte(r1);
      a2 = pick_byte(r2);
      send_frame(a1, a2, $urandom_range(0, 2));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule